// File: doc/BRIEF.md
# SPI Digital Potentiometer Wiper Register Interface

This block is the serial front end of a digital potentiometer. It acts as a mode-0 SPI slave and keeps one or two wiper position registers. The rest of the chip reads those registers to set the resistor taps. A host talks to it in 16-bit frames. The first byte carries a 4-bit wiper address, a 2-bit opcode and the two high data bits. The second byte carries the low eight data bits.

While the command byte is still arriving, the slave answers on MISO. It drives a status bit that reports whether the address and opcode pair is legal. It also drives bit 8 of the addressed wiper. During a read, the second byte it returns holds the low 8 bits of the wiper. A wiper at 256 therefore comes back as an all-ones first byte, which the host decodes as 0x100.

The parameters set the wiper count (1 or 2) and the full scale (128 or 256). SCK, chip select and MOSI are expected to be already synchronous to `clk`. The block detects SCK edges by oversampling them against `clk`.

Top module: `spi_wiper_slave`

## Requirements
- R1: Reset sets every wiper to FULL_SCALE/2. While chip select is high, miso_oe is 0 and miso_out idles at 1.
- R2: A frame with opcode 00 (first-byte bits 3:2) and a legal address (first-byte bits 7:4) loads that wiper with the 10-bit value {first-byte bits 1:0, second byte}. The load happens on the 16th rising SCK edge of the frame.
- R3: A write value above FULL_SCALE stores FULL_SCALE. No wiper ever holds a value above FULL_SCALE.
- R4: A frame with opcode 11 and a legal address returns the low 8 bits of that wiper, MSB first, as the second MISO byte. The wiper is left unchanged.
- R5: In a legal frame, the first MISO byte has bits 7:2 at 1, bit 1 at 1 (the status bit) and bit 0 equal to bit 8 of the addressed wiper. A read of a wiper at 256 returns 0xFF then 0x00.
- R6: Opcode 01 or 10, or an address of NUM_WIPERS or above, drives the status bit (first byte, bit 1) to 0. All later MISO bits are 1, and no wiper changes. Every further bit, including whole later frames, is ignored until chip select rises.
- R7: Raising chip select mid-frame discards the partial frame without touching a wiper. The next frame decodes from its first bit.
- R8: miso_oe is 1 exactly while chip select is low. miso_out changes only on falling SCK edges while selected, and the first frame bit is already valid when chip select falls.
- R9: Several 16-bit frames may follow one another under a single chip select, and each is decoded on its own.
- R10: A one-wiper build treats address 1 as illegal. A one-wiper, 128-step build clamps writes at 128 and returns 0 in first-byte bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK is oversampled against it |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host, sampled on rising SCK |
| miso_out | output | 1 | Serial data to host, updated on falling SCK |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| wiper_flat | output | NUM_WIPERS*VAL_W | Wiper registers, wiper i at bits [i*VAL_W +: VAL_W] |

## Verification
The SCK edge detector sees an edge one `clk` after SCK moves. A wiper therefore changes one `clk` after the 16th rising SCK edge, and a MISO bit changes one `clk` after each falling edge. The bench holds every SCK level for four `clk` cycles. It reads each MISO bit just before the rising edge that ends that bit, and it reads the wipers only after the last falling edge of the frame, so every value it samples has already settled. The status bit comes out in the seventh bit slot, after six rising edges have delivered the address and opcode. The bench checks that bit inside the same returned word as the rest of the frame.

// File: rtl/spi_wiper_slave.sv
module spi_wiper_slave #(
  parameter int NUM_WIPERS = 2,
  parameter int FULL_SCALE = 256,
  localparam int VAL_W = $clog2(FULL_SCALE + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sck,
  input  logic                        cs_n,
  input  logic                        mosi,
  output logic                        miso_out,
  output logic                        miso_oe,
  output logic [NUM_WIPERS*VAL_W-1:0] wiper_flat
);

  localparam logic [VAL_W-1:0] MID = VAL_W'(FULL_SCALE / 2);
  localparam logic [VAL_W-1:0] TOP = VAL_W'(FULL_SCALE);

  logic             sck_q;
  logic [3:0]       cnt;
  logic [14:0]      sh;
  logic             dead_q, err_now, rd_q, miso_q;
  logic [3:0]       addr_q;
  logic [VAL_W-1:0] wip [NUM_WIPERS];

  wire        rise  = ~cs_n & sck & ~sck_q;
  wire        fall  = ~cs_n & ~sck & sck_q;
  wire [15:0] word  = {sh, mosi};
  wire [1:0]  cmd   = word[1:0];
  wire [3:0]  addr  = word[5:2];
  wire        legal = (cmd == 2'b00 || cmd == 2'b11) && (int'(addr) < NUM_WIPERS);
  wire [9:0]  wdata = word[9:0];
  wire [VAL_W-1:0] wval = (wdata > 10'(FULL_SCALE)) ? TOP : wdata[VAL_W-1:0];
  wire        do_wr = rise && cnt == 4'd15 && !dead_q && !rd_q;

  logic [VAL_W-1:0] sel_val;
  logic [9:0]       sel10;
  logic             nxt_bit;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_WIPERS; i++)
      if (int'(addr_q) == i) sel_val = wip[i];
  end

  assign sel10 = 10'(sel_val);

  always_comb begin
    if (cnt < 4'd6)       nxt_bit = 1'b1;
    else if (cnt == 4'd6) nxt_bit = ~err_now;
    else if (dead_q)      nxt_bit = 1'b1;
    else if (cnt == 4'd7) nxt_bit = sel10[8];
    else                  nxt_bit = rd_q ? sel10[4'd15 - cnt] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      dead_q  <= 1'b0;
      err_now <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      miso_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        cnt     <= '0;
        dead_q  <= 1'b0;
        err_now <= 1'b0;
        rd_q    <= 1'b0;
        addr_q  <= '0;
        miso_q  <= 1'b1;
      end else begin
        if (rise) begin
          sh  <= word[14:0];
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) err_now <= 1'b0;
          if (cnt == 4'd5 && !dead_q) begin
            addr_q <= addr;
            rd_q   <= cmd == 2'b11;
            if (!legal) begin
              dead_q  <= 1'b1;
              err_now <= 1'b1;
            end
          end
        end
        if (fall) miso_q <= nxt_bit;
      end
    end
  end

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
    always_ff @(posedge clk) begin
      if (!rst_n)                        wip[g] <= MID;
      else if (do_wr && int'(addr_q) == g) wip[g] <= wval;
    end
    assign wiper_flat[g*VAL_W +: VAL_W] = wip[g];
  end

  assign miso_out = miso_q;
  assign miso_oe  = ~cs_n;

endmodule

// File: rtl/spi_wiper_slave_chk.sv
module spi_wiper_slave_chk #(
  parameter int NUM_WIPERS = 2,
  parameter int FULL_SCALE = 256,
  localparam int VAL_W = $clog2(FULL_SCALE + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sck,
  input logic                        cs_n,
  input logic                        miso_out,
  input logic [NUM_WIPERS*VAL_W-1:0] wiper_flat
);

  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> miso_out);

  p_deselect_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(wiper_flat));

  p_quiet_sck_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(sck) |=> $stable(wiper_flat));

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_bound
    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wiper_flat[g*VAL_W +: VAL_W]) <= FULL_SCALE);
  end

endmodule

bind spi_wiper_slave spi_wiper_slave_chk #(
  .NUM_WIPERS(NUM_WIPERS),
  .FULL_SCALE(FULL_SCALE)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .sck(sck),
  .cs_n(cs_n),
  .miso_out(miso_out),
  .wiper_flat(wiper_flat)
);

// File: tb/spi_wiper_slave_bench.sv
module spi_wiper_slave_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso_out, miso_oe, s_miso, s_oe;
  logic [17:0] wiper_flat;
  logic [7:0]  s_wiper;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  spi_wiper_slave #(.NUM_WIPERS(2), .FULL_SCALE(256)) u_spi_wiper_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso_out(miso_out), .miso_oe(miso_oe), .wiper_flat(wiper_flat));

  spi_wiper_slave #(.NUM_WIPERS(1), .FULL_SCALE(128)) u_spi_wiper_slave_w1 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso_out(s_miso), .miso_oe(s_oe), .wiper_flat(s_wiper));

  localparam int NV = 15;
  localparam logic [15:0] V_TX [NV] = '{16'h0C00, 16'h005A, 16'h1100, 16'h1C00, 16'h13FF,
    16'h012C, 16'h1000, 16'h1C00, 16'h0433, 16'h0855, 16'h2011, 16'hFC00, 16'h0C00,
    16'h00FF, 16'h0C00};
  localparam logic [15:0] V_RX [NV] = '{16'hFE80, 16'hFEFF, 16'hFEFF, 16'hFF00, 16'hFFFF,
    16'hFEFF, 16'hFFFF, 16'hFE00, 16'hFDFF, 16'hFDFF, 16'hFDFF, 16'hFDFF, 16'hFF00,
    16'hFFFF, 16'hFEFF};
  localparam logic [8:0] V_W0 [NV] = '{9'd128, 9'd90, 9'd90, 9'd90, 9'd90, 9'd256, 9'd256,
    9'd256, 9'd256, 9'd256, 9'd256, 9'd256, 9'd256, 9'd255, 9'd255};
  localparam logic [8:0] V_W1 [NV] = '{9'd128, 9'd128, 9'd256, 9'd256, 9'd256, 9'd256,
    9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] tx, input int n,
                            output logic [15:0] rx, output logic [15:0] rxs);
    rx = '1;
    rxs = '1;
    for (int i = 15; i > 15 - n; i--) begin
      mosi = tx[i];
      clks(4);
      rx[i] = miso_out;
      rxs[i] = s_miso;
      sck = 1'b1;
      clks(4);
      sck = 1'b0;
    end
    clks(4);
  endtask

  task automatic sel(input logic lvl);
    cs_n = lvl;
    clks(4);
  endtask

  task automatic frame(input logic [15:0] tx, output logic [15:0] rx, output logic [15:0] rxs);
    sel(1'b0);
    shift_bits(tx, 16, rx, rxs);
    sel(1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clks(3);
    rst_n = 1'b1;
    clks(2);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rx, rxs;
    do_reset();
    chk("R1 w0", 32'(wiper_flat[8:0]), 32'd128);
    chk("R1 w1", 32'(wiper_flat[17:9]), 32'd128);
    chk("R1 small", 32'(s_wiper), 32'd64);
    chk("R1 oe", 32'(miso_oe), 32'd0);
    chk("R1 idle", 32'(miso_out), 32'd1);

    for (int i = 0; i < NV; i++) begin
      frame(V_TX[i], rx, rxs);
      chk((i >= 8 && i <= 11) ? "R6 rx" : "R4/R5 rx", 32'(rx), 32'(V_RX[i]));
      chk("R2/R3 w0", 32'(wiper_flat[8:0]), 32'(V_W0[i]));
      chk("R2/R3 w1", 32'(wiper_flat[17:9]), 32'(V_W1[i]));
    end

    do_reset();
    chk("R1 reset again", 32'(wiper_flat), {14'd0, 9'd128, 9'd128});

    sel(1'b0);
    shift_bits(16'h005A, 10, rx, rxs);
    chk("R8 oe mid-frame", 32'(miso_oe), 32'd1);
    sel(1'b1);
    chk("R8 oe released", 32'(miso_oe), 32'd0);
    chk("R7 partial no write", 32'(wiper_flat[8:0]), 32'd128);
    frame(16'h0C00, rx, rxs);
    chk("R7 realigned read", 32'(rx), 32'hFE80);

    sel(1'b0);
    shift_bits(16'h0433, 16, rx, rxs);
    chk("R6 flag low", 32'(rx), 32'hFDFF);
    shift_bits(16'h0011, 16, rx, rxs);
    chk("R6 later frame ignored", 32'(rx), 32'hFFFF);
    sel(1'b1);
    chk("R6 no write", 32'(wiper_flat[8:0]), 32'd128);

    sel(1'b0);
    shift_bits(16'h1022, 16, rx, rxs);
    chk("R9 first frame", 32'(rx), 32'hFEFF);
    shift_bits(16'h1C00, 16, rx, rxs);
    chk("R9 second frame read", 32'(rx), 32'hFE22);
    sel(1'b1);
    chk("R9 w1", 32'(wiper_flat[17:9]), 32'h22);

    frame(16'h1005, rx, rxs);
    chk("R10 small addr1 flag", 32'(rxs), 32'hFDFF);
    chk("R10 small unchanged", 32'(s_wiper), 32'd64);
    chk("R2 big w1", 32'(wiper_flat[17:9]), 32'd5);
    frame(16'h00C8, rx, rxs);
    chk("R10 small clamp", 32'(s_wiper), 32'd128);
    chk("R10 small bit0", 32'(rxs), 32'hFEFF);
    chk("R2 big w0", 32'(wiper_flat[8:0]), 32'd200);
    frame(16'h0C00, rx, rxs);
    chk("R10 small read", 32'(rxs), 32'hFE80);
    chk("R4 big read", 32'(rx), 32'hFEC8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule